// File: doc/BRIEF.md
# Dual-Mode Capture/Compare Timer

A timer/counter that runs either as one 16-bit count or as two independent 8-bit counts, a high byte and a low byte. It advances on a prescaled tick enable. In counter mode it advances on edges of an external pin instead. When a count rolls over, it reloads from a reload register and raises an overflow flag. In compare mode a match against a compare register raises a flag. In capture mode, selected pin edges copy the count into a capture register and can also reload the count.

Software reaches every register through a flat write/read port. The port has separate write and read addresses and an asynchronous read path. Two interrupt lines are derived from the status flags. One serves the full count or the high byte. The other serves the low byte and is live only in split mode. The external pin passes through a two-flop synchroniser. Edges are found by comparing the synchronised level with its value one cycle earlier, so a pin change acts on the third clock edge after it appears.

Top module: `dual_cc_timer`

## Requirements
- R1: Register addresses are 0 control, 1 status, 2 count, 3 compare, 4 reload and 5 capture (read only). Control bit 10 is run. With run set and control bit 0 (split) clear, every cycle with the tick high adds one to the 16-bit count. On the tick that moves the count on from all ones, the count loads the 16-bit reload value and status bit 0 (main overflow) sets.
- R2: With split set, the high and low bytes count on their own. Each byte reloads from its own byte of the reload register when it wraps. The high wrap sets status bit 0 and the low wrap sets status bit 1 (low overflow). A carry from the low byte into the high byte exists only with split clear, and status bit 1 never sets there.
- R3: With control bits 6:5 at 00 (compare mode), status bit 2 sets when an advance makes the count equal to the compare value. In split mode this applies to the high byte against the high compare byte. With split set, status bit 3 sets when the low byte advances to the low compare byte.
- R4: Gating is active when control bit 1 is set, bit 2 (pin drive enable) and bit 3 (counter mode) are clear, and the dual-edge reload case of R8 is not configured. The full count (split clear) or the high byte (split set) then advances only while the synchronised pin is high. The low byte in split mode is never gated.
- R5: With control bit 3 set, the full count (or the high byte) advances once per synchronised rising pin edge. The tick and the gating bit have no effect on it.
- R6: Control bits 6:5 choose the capture edges: 01 rising, 10 falling, 11 both. A selected edge copies the 16-bit count into the capture register and sets status bit 2.
- R7: With control bit 7 set, a capture also loads the reload value into the count: all 16 bits with split clear, the high byte with split set.
- R8: With edges 11, bit 7 and bit 1 all set, control bit 4 (polarity) picks the edge that captures without reloading. With polarity 0 the falling edge does not reload; with polarity 1 the rising edge does not reload.
- R9: The main interrupt is control bit 8 AND (status bit 0 OR bit 2). The low interrupt is control bit 9 AND split AND (status bit 1 OR bit 3).
- R10: Writing the status register replaces the four flags. A flag set by hardware in the same cycle wins over a written zero.
- R11: Reset clears all registers, so every address reads zero and both interrupts are low.
- R12: With run clear, the count holds, and no overflow, match or capture takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaled count enable |
| pin_i | input | 1 | External timer pin, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 16 | Read data, combinational from rd_addr_i |
| irq_main_o | output | 1 | Full/high timer interrupt request |
| irq_low_o | output | 1 | Low byte interrupt request |

## Verification
A wrong carry or reload decision shows up as a wrong count on the read port. It appears on the very next tick after the wrap, and every later read carries it forward. A wrong edge or gating decision appears three clock edges after the pin moves: as a count that moved or failed to move, as a capture register holding a stale value, or as a reload taken on the edge that should have skipped it. Flag errors reach the interrupt pins in the cycle after the event, because the interrupts decode the status register directly.

// File: rtl/dct_pkg.sv
package dct_pkg;
   localparam int CTRL_W = 11;

   localparam logic [2:0] ADDR_CTRL = 3'd0;
   localparam logic [2:0] ADDR_STAT = 3'd1;
   localparam logic [2:0] ADDR_CNT  = 3'd2;
   localparam logic [2:0] ADDR_CMP  = 3'd3;
   localparam logic [2:0] ADDR_RLD  = 3'd4;
   localparam logic [2:0] ADDR_CAP  = 3'd5;

   // capture edge select
   localparam logic [1:0] EDGE_NONE = 2'b00;
   localparam logic [1:0] EDGE_BOTH = 2'b11;

   typedef struct packed {
      logic       run;       // 10
      logic       ie_low;    // 9
      logic       ie_main;   // 8
      logic       cap_rld;   // 7
      logic [1:0] cap_edge;  // 6:5
      logic       pol;       // 4
      logic       cnt_mode;  // 3
      logic       out_en;    // 2
      logic       gate_en;   // 1
      logic       split;     // 0
   } ctrl_t;

   typedef struct packed {
      logic ccl;   // 3
      logic ccf;   // 2
      logic tfl;   // 1
      logic tf;    // 0
   } stat_t;
endpackage

// File: rtl/dct_pin_edge.sv
module dct_pin_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dct_pin_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign lvl_o  = sync_q[STAGES-1];
   assign rise_o = sync_q[STAGES-1] & ~prev_q;
   assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/dct_slice.sv
module dct_slice #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wr_val_i,
   input  logic         ld_i,
   input  logic [W-1:0] ld_val_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o,
   output logic [W-1:0] nxt_o,
   output logic         ones_o
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt_q;

   always_comb begin
      if (wr_i)       nxt_o = wr_val_i;
      else if (ld_i)  nxt_o = ld_val_i;
      else if (inc_i) nxt_o = cnt_q + ONE;
      else            nxt_o = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= nxt_o;
   end

   assign cnt_o  = cnt_q;
   assign ones_o = &cnt_q;
endmodule

// File: rtl/dual_cc_timer.sv
module dual_cc_timer
   import dct_pkg::*;
#(
   parameter int HALF_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_i,
   input  logic                pin_i,
   input  logic                wr_en_i,
   input  logic [2:0]          wr_addr_i,
   input  logic [2*HALF_W-1:0] wr_data_i,
   input  logic [2:0]          rd_addr_i,
   output logic [2*HALF_W-1:0] rd_data_o,
   output logic                irq_main_o,
   output logic                irq_low_o
);
   localparam int CNT_W = 2 * HALF_W;

   if (CNT_W < CTRL_W) begin : g_bad_width
      $error("dual_cc_timer: HALF_W too small to hold the control word");
   end

   ctrl_t             ctrl_q;
   stat_t             stat_q, stat_set;
   logic [CNT_W-1:0]  cmp_q, rld_q, cap_q, cnt, nxt;
   logic [1:0]        inc, ld, ones;

   logic wr_ctrl, wr_stat, wr_cnt, wr_cmp, wr_rld;
   assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
   assign wr_stat = wr_en_i && (wr_addr_i == ADDR_STAT);
   assign wr_cnt  = wr_en_i && (wr_addr_i == ADDR_CNT);
   assign wr_cmp  = wr_en_i && (wr_addr_i == ADDR_CMP);
   assign wr_rld  = wr_en_i && (wr_addr_i == ADDR_RLD);

   // pin conditioning
   logic pin_lvl, pin_rise, pin_fall;
   dct_pin_edge #(.STAGES(SYNC_STAGES)) u_pin (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_i),
      .lvl_o  (pin_lvl),
      .rise_o (pin_rise),
      .fall_o (pin_fall)
   );

   // event decode
   logic split, run, dual_rld, gate_act, cap_on, cap_evt, skip_rld, cap_reload;
   logic main_inc, low_tick, main_ovf, low_ovf, main_adv, hi_match, lo_match;

   assign split    = ctrl_q.split;
   assign run      = ctrl_q.run;
   assign dual_rld = ctrl_q.cap_rld && (ctrl_q.cap_edge == EDGE_BOTH);
   assign gate_act = ctrl_q.gate_en && !ctrl_q.out_en && !ctrl_q.cnt_mode && !dual_rld;
   assign cap_on   = ctrl_q.cap_edge != EDGE_NONE;

   assign main_inc = run && !wr_cnt &&
                     (ctrl_q.cnt_mode ? pin_rise : (tick_i && (!gate_act || pin_lvl)));
   assign low_tick = run && !wr_cnt && tick_i;

   assign cap_evt    = run && ((ctrl_q.cap_edge[0] && pin_rise) ||
                               (ctrl_q.cap_edge[1] && pin_fall));
   assign skip_rld   = dual_rld && ctrl_q.gate_en &&
                       (ctrl_q.pol ? pin_rise : pin_fall);
   assign cap_reload = cap_evt && ctrl_q.cap_rld && !skip_rld && !wr_cnt;

   assign inc[0]   = split ? low_tick : main_inc;
   assign inc[1]   = split ? main_inc : (main_inc && ones[0]);
   assign main_ovf = inc[1] && ones[1];
   assign low_ovf  = split && inc[0] && ones[0];
   assign ld[1]    = main_ovf || cap_reload;
   assign ld[0]    = split ? low_ovf : (main_ovf || cap_reload);

   // counter halves
   for (genvar g = 0; g < 2; g++) begin : g_half
      dct_slice #(.W(HALF_W)) u_slice (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_i     (wr_cnt),
         .wr_val_i (wr_data_i[g*HALF_W +: HALF_W]),
         .ld_i     (ld[g]),
         .ld_val_i (rld_q[g*HALF_W +: HALF_W]),
         .inc_i    (inc[g]),
         .cnt_o    (cnt[g*HALF_W +: HALF_W]),
         .nxt_o    (nxt[g*HALF_W +: HALF_W]),
         .ones_o   (ones[g])
      );
   end

   // compare and flag set
   assign main_adv = split ? inc[1] : inc[0];
   assign hi_match = !cap_on && main_adv &&
                     (split ? (nxt[CNT_W-1:HALF_W] == cmp_q[CNT_W-1:HALF_W])
                            : (nxt == cmp_q));
   assign lo_match = split && inc[0] && (nxt[HALF_W-1:0] == cmp_q[HALF_W-1:0]);

   always_comb begin
      stat_set.tf  = main_ovf;
      stat_set.tfl = low_ovf;
      stat_set.ccf = hi_match || cap_evt;
      stat_set.ccl = lo_match;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         stat_q <= '0;
         cmp_q  <= '0;
         rld_q  <= '0;
         cap_q  <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
         if (wr_cmp)  cmp_q  <= wr_data_i;
         if (wr_rld)  rld_q  <= wr_data_i;
         if (cap_evt) cap_q  <= cnt;
         stat_q <= (wr_stat ? stat_t'(wr_data_i[3:0]) : stat_q) | stat_set;
      end
   end

   // read path
   always_comb begin
      case (rd_addr_i)
         ADDR_CTRL: rd_data_o = CNT_W'(ctrl_q);
         ADDR_STAT: rd_data_o = CNT_W'(stat_q);
         ADDR_CNT:  rd_data_o = cnt;
         ADDR_CMP:  rd_data_o = cmp_q;
         ADDR_RLD:  rd_data_o = rld_q;
         ADDR_CAP:  rd_data_o = cap_q;
         default:   rd_data_o = '0;
      endcase
   end

   assign irq_main_o = ctrl_q.ie_main && (stat_q.tf || stat_q.ccf);
   assign irq_low_o  = ctrl_q.ie_low && split && (stat_q.tfl || stat_q.ccl);
endmodule

// File: rtl/dct_timer_chk.sv
module dct_timer_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         run,
   input logic         split,
   input logic         cnt_wr,
   input logic         stat_wr,
   input logic [W-1:0] cnt,
   input logic         main_ovf,
   input logic         cap_evt,
   input logic [W-1:0] cap,
   input logic [3:0]   stat,
   input logic         irq_low
);
   // R1: a rollover leaves the main overflow flag set
   p_ovf_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
      main_ovf |=> stat[0]);

   // R2: low overflow only rises in split mode or by a status write
   p_low_split_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[1]) |-> ($past(split) || $past(stat_wr)));

   // R6: capture register takes the count seen at the edge
   p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> (cap == $past(cnt)));

   // R9: low interrupt silent outside split mode
   p_irq_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !split |-> !irq_low);

   // R12: stopped timer keeps its count
   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> $stable(cnt));
endmodule

bind dual_cc_timer dct_timer_chk #(.W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (run),
   .split    (split),
   .cnt_wr   (wr_cnt),
   .stat_wr  (wr_stat),
   .cnt      (cnt),
   .main_ovf (main_ovf),
   .cap_evt  (cap_evt),
   .cap      (cap_q),
   .stat     (stat_q),
   .irq_low  (irq_low_o)
);

// File: tb/dual_cc_timer_tb.sv
`timescale 1ns/1ps
module dual_cc_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        pin_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [2:0]  wr_addr_i = '0;
   logic [15:0] wr_data_i = '0;
   logic [2:0]  rd_addr_i = '0;
   logic [15:0] rd_data_o;
   logic        irq_main_o, irq_low_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   dual_cc_timer u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .pin_i      (pin_i),
      .wr_en_i    (wr_en_i),
      .wr_addr_i  (wr_addr_i),
      .wr_data_i  (wr_data_i),
      .rd_addr_i  (rd_addr_i),
      .rd_data_o  (rd_data_o),
      .irq_main_o (irq_main_o),
      .irq_low_o  (irq_low_o)
   );

   localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_CNT = 3'd2,
                          A_CMP = 3'd3, A_RLD = 3'd4, A_CAP = 3'd5;

   typedef struct packed {
      logic [15:0] ctrl;
      logic [15:0] cnt;
      logic [15:0] cmp;
      logic [15:0] rld;
      logic        pin;
      logic [7:0]  ticks;
      logic [15:0] exp_cnt;
      logic [3:0]  exp_stat;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{16'h0400, 16'h0010, 16'h0100, 16'h0000, 1'b0, 8'd5, 16'h0015, 4'h0}, // R1 plain
      '{16'h0400, 16'hFFFE, 16'h0000, 16'h1234, 1'b0, 8'd3, 16'h1235, 4'h1}, // R1 wrap
      '{16'h0400, 16'h00F0, 16'h00F3, 16'h0000, 1'b0, 8'd5, 16'h00F5, 4'h4}, // R3 16-bit
      '{16'h0400, 16'h00FE, 16'h8000, 16'h0000, 1'b0, 8'd3, 16'h0101, 4'h0}, // R2 carry
      '{16'h0401, 16'h10FE, 16'h1312, 16'h5060, 1'b0, 8'd4, 16'h1462, 4'h6}, // R2 R3 low wrap
      '{16'h0401, 16'hFE05, 16'h0007, 16'h7000, 1'b0, 8'd3, 16'h7108, 4'h9}, // R2 R3 high wrap
      '{16'h0402, 16'h0100, 16'h8000, 16'h0000, 1'b0, 8'd6, 16'h0100, 4'h0}, // R4 gated low
      '{16'h0402, 16'h0100, 16'h8000, 16'h0000, 1'b1, 8'd6, 16'h0106, 4'h0}, // R4 gated high
      '{16'h0406, 16'h0100, 16'h8000, 16'h0000, 1'b0, 8'd6, 16'h0106, 4'h0}, // R4 pin drive on
      '{16'h0403, 16'h2020, 16'h8000, 16'h0000, 1'b0, 8'd5, 16'h2025, 4'h0}, // R4 split
      '{16'h0000, 16'h0040, 16'h8000, 16'h0000, 1'b0, 8'd5, 16'h0040, 4'h0}, // R12 stopped
      '{16'h0408, 16'h0030, 16'h8000, 16'h0000, 1'b0, 8'd5, 16'h0030, 4'h0}  // R5 tick ignored
   };

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] v);
      rd_addr_i = a;
      #1;
      v = rd_data_o;
   endtask

   task automatic ticks(input int n);
      if (n > 0) begin
         @(negedge clk);
         tick_i = 1'b1;
         repeat (n) @(negedge clk);
         tick_i = 1'b0;
      end
   endtask

   task automatic pin_to(input logic v);
      @(negedge clk);
      pin_i = v;
      repeat (5) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: reset state
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), v);
         check($sformatf("R11 reset addr %0d", a), v, 16'h0000);
      end
      check("R11 irq_main reset", {15'b0, irq_main_o}, 16'h0);
      check("R11 irq_low reset", {15'b0, irq_low_o}, 16'h0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         wr(A_CTRL, 16'h0000);
         pin_to(VEC[i].pin);
         wr(A_CNT, VEC[i].cnt);
         wr(A_CMP, VEC[i].cmp);
         wr(A_RLD, VEC[i].rld);
         wr(A_STAT, 16'h0000);
         wr(A_CTRL, VEC[i].ctrl);
         ticks(int'(VEC[i].ticks));
         @(negedge clk);
         rd(A_CNT, v);
         check($sformatf("vector %0d count (R1/R2/R4/R5/R12)", i), v, VEC[i].exp_cnt);
         rd(A_STAT, v);
         check($sformatf("vector %0d status (R1/R2/R3)", i), v, {12'b0, VEC[i].exp_stat});
      end

      // R5: counter mode counts pin rising edges, gating bit ignored
      wr(A_CTRL, 16'h0000);
      pin_to(1'b0);
      wr(A_CNT, 16'h0000);
      wr(A_CTRL, 16'h040A);
      for (int k = 0; k < 3; k++) begin
         pin_to(1'b1);
         pin_to(1'b0);
      end
      rd(A_CNT, v);
      check("R5 pin edge count", v, 16'h0003);

      // R6: rising capture, no reload
      wr(A_CTRL, 16'h0000);
      wr(A_CNT, 16'h0100);
      wr(A_RLD, 16'h0777);
      wr(A_STAT, 16'h0000);
      wr(A_CTRL, 16'h0420);
      pin_to(1'b1);
      rd(A_CAP, v);
      check("R6 capture value", v, 16'h0100);
      rd(A_STAT, v);
      check("R6 capture flag", v, 16'h0004);
      wr(A_CNT, 16'h0200);
      pin_to(1'b0);
      rd(A_CAP, v);
      check("R6 falling edge not selected", v, 16'h0100);

      // R7: capture with reload
      wr(A_CTRL, 16'h04A0);
      pin_to(1'b1);
      rd(A_CAP, v);
      check("R7 capture before reload", v, 16'h0200);
      rd(A_CNT, v);
      check("R7 count reloaded", v, 16'h0777);
      pin_to(1'b0);

      // R8: both edges, gating bit clear -> both reload
      wr(A_CTRL, 16'h04E0);
      wr(A_CNT, 16'h0100);
      pin_to(1'b1);
      rd(A_CNT, v);
      check("R8 both-edge reload rise", v, 16'h0777);
      wr(A_CNT, 16'h0110);
      pin_to(1'b0);
      rd(A_CNT, v);
      check("R8 both-edge reload fall", v, 16'h0777);

      // R8: polarity 0 skips falling
      wr(A_CTRL, 16'h04E2);
      wr(A_RLD, 16'h0888);
      wr(A_CNT, 16'h0300);
      pin_to(1'b1);
      rd(A_CNT, v);
      check("R8 pol0 rise reloads", v, 16'h0888);
      wr(A_CNT, 16'h0400);
      pin_to(1'b0);
      rd(A_CAP, v);
      check("R8 pol0 fall captures", v, 16'h0400);
      rd(A_CNT, v);
      check("R8 pol0 fall no reload", v, 16'h0400);

      // R8: polarity 1 skips rising
      wr(A_CTRL, 16'h04F2);
      wr(A_CNT, 16'h0500);
      pin_to(1'b1);
      rd(A_CAP, v);
      check("R8 pol1 rise captures", v, 16'h0500);
      rd(A_CNT, v);
      check("R8 pol1 rise no reload", v, 16'h0500);
      wr(A_CNT, 16'h0600);
      pin_to(1'b0);
      rd(A_CNT, v);
      check("R8 pol1 fall reloads", v, 16'h0888);

      // R10: hardware set wins over a same-cycle clear
      wr(A_CTRL, 16'h0000);
      wr(A_CNT, 16'hFFFF);
      wr(A_RLD, 16'h0000);
      wr(A_CMP, 16'h8000);
      wr(A_STAT, 16'h0000);
      wr(A_CTRL, 16'h0400);
      @(negedge clk);
      tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = A_STAT; wr_data_i = 16'h0000;
      @(negedge clk);
      tick_i = 1'b0; wr_en_i = 1'b0;
      rd(A_STAT, v);
      check("R10 set beats clear", v, 16'h0001);
      wr(A_STAT, 16'h000A);
      rd(A_STAT, v);
      check("R10 software write", v, 16'h000A);

      // R9: interrupt decode
      wr(A_CTRL, 16'h0100);
      wr(A_STAT, 16'h0004);
      check("R9 irq_main on ccf", {15'b0, irq_main_o}, 16'h1);
      wr(A_STAT, 16'h0002);
      check("R9 irq_main off", {15'b0, irq_main_o}, 16'h0);
      wr(A_CTRL, 16'h0200);
      check("R9 irq_low needs split", {15'b0, irq_low_o}, 16'h0);
      wr(A_CTRL, 16'h0201);
      check("R9 irq_low split", {15'b0, irq_low_o}, 16'h1);

      finish_run();
   end
endmodule